// File: doc/BRIEF.md
# Configurable Single-Port Masked SRAM

A synchronous memory with one shared read/write port. Each active clock edge performs at most one operation: a read that loads the addressed word onto the data output, or a masked write that updates selected bits or bytes of the addressed word. Parameters select the depth, the word width, the address width and the active clock edge. They also select the polarity of the chip enable, the global write enable and the write mask, whether each of these three controls exists at all, and whether a mask element covers one bit or one byte.

Used with its defaults, the memory holds 1024 words of 8 bits. It runs on the rising edge, and its chip enable, global write enable and per-bit write mask are all active-low. A synchronous reset clears only the data output register. The array contents are undefined until written.

Top module: `spram_cfg`

## Requirements
- R1: While `rst_n` is low at an active clock edge, `dout` becomes zero after that edge.
- R2: When the chip enable is asserted and the global write enable is deasserted at an active edge, `dout` shows the word stored at `addr` before that edge. A write earlier to the same address is visible to the read that follows it.
- R3: When the chip enable and the global write enable are asserted, each bit whose mask element is asserted takes the matching `din` bit, and every other bit of the word keeps its value. By default the mask is active-low: `wmask[i]` = 0 enables bit i.
- R4: `dout` keeps its previous value on every edge that is not a read, including write edges.
- R5: When the chip enable is deasserted, the edge neither reads nor writes. `dout` holds, and the stored word is unchanged.
- R6: When the global write enable is asserted and no mask element is asserted, the edge neither writes nor reads. `dout` holds, and the stored word is unchanged.
- R7: With byte granularity, the mask is WIDTH/8 wide and element k covers bits 8k+7..8k. The clock edge and each control polarity follow their parameters. A 16-bit instance has active-high controls and a falling clock edge: `wmask` = 2'b01 writes only bits 7..0, and 2'b10 writes only bits 15..8.
- R8: When the global write enable is configured absent, an edge with the chip enable asserted and at least one mask element asserted is a write. An edge with the chip enable asserted and no mask element asserted is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by CLK_RISE |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| ce | input | 1 | Chip enable; polarity set by CE_HIGH, ignored when HAS_CE=0 |
| we | input | 1 | Global write enable; polarity set by WE_HIGH, ignored when HAS_WE=0 |
| wmask | input | MW | Write mask, per bit or per byte; polarity set by MASK_HIGH |
| addr | input | AW | Word address |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Registered read data |

## Verification
The bound assertions check on every edge that `dout` stays unchanged on disabled edges, on write edges and on edges with an empty mask. They also check that a full-word write followed at once by a read of the same address returns the written data. The bench scenarios are what show that a partial mask leaves the unselected bits intact, that a blocked write really did not reach the array (seen through a later read), and that byte lanes, active-high polarities, the falling edge and the missing write enable behave as configured. These scenarios run on a second, differently configured instance.

// File: rtl/spram_cfg.sv
module spram_cfg #(
  parameter int DEPTH     = 1024,
  parameter int WIDTH     = 8,
  parameter int AW        = 10,
  parameter bit CLK_RISE  = 1'b1,
  parameter bit HAS_CE    = 1'b1,
  parameter bit CE_HIGH   = 1'b0,
  parameter bit HAS_WE    = 1'b1,
  parameter bit WE_HIGH   = 1'b0,
  parameter int MASK_MODE = 1,
  parameter bit MASK_HIGH = 1'b0,
  localparam int MW = (MASK_MODE == 2) ? ((WIDTH / 8 > 0) ? WIDTH / 8 : 1) : WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             we,
  input  logic [MW-1:0]    wmask,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
    $fatal(1, "spram_cfg: WIDTH must be 1..32");
  end
  if (DEPTH < 1 || DEPTH > 8192 || DEPTH > (1 << AW)) begin : g_bad_depth
    $fatal(1, "spram_cfg: DEPTH must be 1..8192 and fit the address");
  end
  if (MASK_MODE == 2 && (WIDTH % 8) != 0) begin : g_bad_bytes
    $fatal(1, "spram_cfg: byte mask needs WIDTH a multiple of 8");
  end
  if (MASK_MODE < 0 || MASK_MODE > 2) begin : g_bad_mode
    $fatal(1, "spram_cfg: MASK_MODE is 0 (none), 1 (bit) or 2 (byte)");
  end

  logic [WIDTH-1:0] mem [DEPTH];
  logic             clk_i;
  logic             ce_on;
  logic             wr_req;
  logic             rd_en;
  logic             wr_en;
  logic [MW-1:0]    lane_on;
  logic [WIDTH-1:0] bit_en;

  assign clk_i   = CLK_RISE ? clk : ~clk;
  assign ce_on   = HAS_CE ? (ce == CE_HIGH) : 1'b1;
  assign lane_on = (MASK_MODE == 0) ? '1 : (MASK_HIGH ? wmask : ~wmask);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK_MODE == 2) begin : g_byte
      assign bit_en[i] = lane_on[i / 8];
    end else if (MASK_MODE == 1) begin : g_per_bit
      assign bit_en[i] = lane_on[i];
    end else begin : g_whole
      assign bit_en[i] = 1'b1;
    end
  end

  assign wr_req = HAS_WE ? (we == WE_HIGH) : |lane_on;
  assign wr_en  = ce_on & wr_req & (|bit_en);
  assign rd_en  = ce_on & ~wr_req;

  always_ff @(posedge clk_i) begin
    if (!rst_n)
      dout <= '0;
    else if (rd_en)
      dout <= mem[addr];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      for (int i = 0; i < WIDTH; i++)
        if (bit_en[i]) mem[addr][i] <= din[i];
    end
  end

endmodule

// File: rtl/spram_cfg_chk.sv
module spram_cfg_chk #(
  parameter int DEPTH     = 1024,
  parameter int WIDTH     = 8,
  parameter int AW        = 10,
  parameter bit CLK_RISE  = 1'b1,
  parameter bit HAS_CE    = 1'b1,
  parameter bit CE_HIGH   = 1'b0,
  parameter bit HAS_WE    = 1'b1,
  parameter bit WE_HIGH   = 1'b0,
  parameter int MASK_MODE = 1,
  parameter bit MASK_HIGH = 1'b0,
  parameter int MW        = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic             we,
  input logic [MW-1:0]    wmask,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout
);
  logic          ck;
  logic          en;
  logic          wq;
  logic [MW-1:0] lanes;
  logic          any_lane;
  logic          all_lane;
  logic          rd;
  logic          wr_full;

  assign ck       = CLK_RISE ? clk : ~clk;
  assign en       = HAS_CE ? (ce == CE_HIGH) : 1'b1;
  assign lanes    = MASK_HIGH ? wmask : ~wmask;
  assign any_lane = (MASK_MODE == 0) ? 1'b1 : |lanes;
  assign all_lane = (MASK_MODE == 0) ? 1'b1 : &lanes;
  assign wq       = HAS_WE ? (we == WE_HIGH) : any_lane;
  assign rd       = en & ~wq;
  assign wr_full  = en & wq & all_lane;

  a_r4_hold_non_read: assert property (@(posedge ck) disable iff (!rst_n)
    !rd |=> $stable(dout));

  a_r5_ce_off_hold: assert property (@(posedge ck) disable iff (!rst_n)
    !en |=> $stable(dout));

  a_r6_empty_mask_hold: assert property (@(posedge ck) disable iff (!rst_n)
    (en && wq && !any_lane) |=> $stable(dout));

  a_r2_raw_same_addr: assert property (@(posedge ck) disable iff (!rst_n)
    (rd && $past(wr_full) && addr == $past(addr)) |=> dout == $past(din, 2));
endmodule

bind spram_cfg spram_cfg_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .CLK_RISE(CLK_RISE),
  .HAS_CE(HAS_CE), .CE_HIGH(CE_HIGH), .HAS_WE(HAS_WE), .WE_HIGH(WE_HIGH),
  .MASK_MODE(MASK_MODE), .MASK_HIGH(MASK_HIGH), .MW(MW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .wmask(wmask),
  .addr(addr), .din(din), .dout(dout)
);

// File: tb/spram_cfg_tb.sv
module spram_cfg_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic rst_n = 1'b0;

  logic       ce1 = 1'b1, we1 = 1'b1;
  logic [7:0] mk1 = 8'hFF, d1 = '0, q1;
  logic [9:0] a1 = '0;

  logic        ce2 = 1'b0;
  logic [1:0]  mk2 = 2'b00;
  logic [5:0]  a2 = '0;
  logic [15:0] d2 = '0, q2;

  spram_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce1), .we(we1), .wmask(mk1),
    .addr(a1), .din(d1), .dout(q1)
  );

  spram_cfg #(
    .DEPTH(64), .WIDTH(16), .AW(6), .CLK_RISE(1'b0),
    .HAS_CE(1'b1), .CE_HIGH(1'b1), .HAS_WE(1'b0), .WE_HIGH(1'b1),
    .MASK_MODE(2), .MASK_HIGH(1'b1)
  ) u_dut2 (
    .clk(clk), .rst_n(rst_n), .ce(ce2), .we(1'b0), .wmask(mk2),
    .addr(a2), .din(d2), .dout(q2)
  );

  logic [7:0]  m1 [1024];
  bit          k1 [1024];
  logic [7:0]  e1;
  bit          e1k;
  logic [15:0] m2 [64];
  logic [15:0] e2;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step1(input logic c, input logic w, input logic [7:0] mk,
                       input logic [9:0] a, input logic [7:0] d, input string tag);
    ce1 = c; we1 = w; mk1 = mk; a1 = a; d1 = d;
    @(posedge clk);
    if (!c) begin
      if (w) begin
        e1 = m1[a]; e1k = k1[a];
      end else if (mk != 8'hFF) begin
        for (int i = 0; i < 8; i++) if (!mk[i]) m1[a][i] = d[i];
        if (mk == 8'h00) k1[a] = 1'b1;
      end
    end
    @(negedge clk); #2;
    if (e1k) chk(q1 === e1, tag, 32'(q1), 32'(e1));
  endtask

  task automatic step2(input logic c, input logic [1:0] mk, input logic [5:0] a,
                       input logic [15:0] d, input string tag);
    ce2 = c; mk2 = mk; a2 = a; d2 = d;
    @(negedge clk);
    if (c) begin
      if (mk == 2'b00) e2 = m2[a];
      else begin
        if (mk[0]) m2[a][7:0]  = d[7:0];
        if (mk[1]) m2[a][15:8] = d[15:8];
      end
    end
    @(posedge clk); #2;
    chk(q2 === e2, tag, 32'(q2), 32'(e2));
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) k1[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(q1 === 8'h00, "R1 dut1 reset", 32'(q1), 32'h0);
    @(posedge clk); #2;
    chk(q2 === 16'h0, "R1 dut2 reset", 32'(q2), 32'h0);
    e1 = 8'h00; e1k = 1'b1; e2 = 16'h0;
    @(negedge clk); #2;
    rst_n = 1'b1;

    for (int a = 0; a < 16; a++) step1(1'b0, 1'b0, 8'h00, 10'(a), 8'(a * 37 + 5), "R4 write holds dout");
    step1(1'b0, 1'b0, 8'h00, 10'd1023, 8'hC3, "R3 full write top");
    step1(1'b0, 1'b0, 8'h00, 10'd512, 8'h96, "R3 full write mid");
    for (int a = 0; a < 16; a++) step1(1'b0, 1'b1, 8'hFF, 10'(a), 8'h00, "R2 read");
    step1(1'b0, 1'b1, 8'h00, 10'd1023, 8'h00, "R2 read top");
    step1(1'b0, 1'b1, 8'h55, 10'd512, 8'h00, "R2 read mid");

    step1(1'b0, 1'b0, 8'hF0, 10'd3, 8'hFF, "R3 partial write");
    step1(1'b0, 1'b1, 8'hFF, 10'd3, 8'h00, "R3 partial readback");
    step1(1'b0, 1'b0, 8'h5A, 10'd2, 8'hA5, "R3 scattered bits");
    step1(1'b0, 1'b1, 8'hFF, 10'd2, 8'h00, "R3 scattered readback");

    step1(1'b0, 1'b1, 8'hFF, 10'd7, 8'h00, "R2 read before empty mask");
    step1(1'b0, 1'b0, 8'hFF, 10'd4, 8'h00, "R6 empty mask holds dout");
    step1(1'b0, 1'b1, 8'hFF, 10'd4, 8'h00, "R6 word unchanged");

    step1(1'b1, 1'b0, 8'h00, 10'd5, 8'h00, "R5 disabled write holds dout");
    step1(1'b1, 1'b1, 8'hFF, 10'd6, 8'h00, "R5 disabled read holds dout");
    step1(1'b0, 1'b1, 8'hFF, 10'd5, 8'h00, "R5 word unchanged");

    step1(1'b0, 1'b1, 8'hFF, 10'd7, 8'h00, "R2 read");
    step1(1'b0, 1'b0, 8'h00, 10'd8, 8'hEE, "R4 write cycle holds");
    step1(1'b0, 1'b0, 8'h00, 10'd9, 8'h3C, "R4 write cycle holds");
    step1(1'b0, 1'b1, 8'hFF, 10'd9, 8'h00, "R2 read after write");
    step1(1'b0, 1'b1, 8'hFF, 10'd8, 8'h00, "R2 read after write");
    step1(1'b0, 1'b1, 8'hFF, 10'd0, 8'h00, "R2 read bottom");
    step1(1'b1, 1'b1, 8'hFF, 10'd0, 8'h00, "R4 idle");

    @(posedge clk); #2;
    for (int i = 0; i < 64; i++) m2[i] = 16'h0;
    step2(1'b1, 2'b11, 6'd5, 16'hABCD, "R8 mask selects write");
    step2(1'b1, 2'b11, 6'd63, 16'h7E81, "R8 mask selects write");
    step2(1'b1, 2'b00, 6'd5, 16'h0000, "R8 empty mask reads");
    step2(1'b1, 2'b01, 6'd5, 16'h1234, "R7 low byte lane");
    step2(1'b1, 2'b00, 6'd5, 16'h0000, "R7 low byte readback");
    step2(1'b1, 2'b10, 6'd5, 16'h5600, "R7 high byte lane");
    step2(1'b1, 2'b00, 6'd5, 16'h0000, "R7 high byte readback");
    step2(1'b0, 2'b11, 6'd5, 16'hFFFF, "R7 active-high ce off");
    step2(1'b1, 2'b00, 6'd5, 16'h0000, "R7 word unchanged");
    step2(1'b1, 2'b00, 6'd63, 16'h0000, "R8 read top");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule